// File: doc/BRIEF.md
# Framebuffer Word Fetcher

This block keeps a small pixel FIFO topped up with 32-bit words read from a framebuffer in memory. Software programs a byte base address. On every frame-start pulse the block empties its FIFO, abandons any fetch still owed to the old frame, and loads a running fetch pointer from the base. While the FIFO has enough free room, the block then issues single-word read requests. Each accepted request moves the pointer on by one word. The pixel consumer pulls words in order through a pop port.

The base register is double-buffered. A rewrite takes effect only at the next frame start. The block raises a frame-taken flag at every frame start, and software uses it to learn when the base may be rewritten safely. A second flag records pops made while the FIFO was empty. Each flag can be enabled onto a single interrupt line.

Register map (index on `reg_addr`): 0 = control, 1 = base, 2 = fetch pointer (read only), 3 = flags (write 1 to clear). Control bit 0 selects the refill mark. Control bit 1 enables the frame-taken flag onto `irq`. Control bit 2 enables the empty-pop flag onto `irq`. In the flags register, bit 0 is frame-taken and bit 1 is empty-pop.

Top module: `fb_fetch_ctrl`

## Requirements
- R1: After reset, the fetch pointer, the flags and `irq` are zero, `pix_valid` is low, and no read request is raised before the first frame-start pulse.
- R2: A write to index 1 stores the value with bits [1:0] forced to 0. A read of index 1 returns the stored value.
- R3: One cycle after a frame-start pulse, the fetch pointer (index 2) equals the stored base. The next request presents that address on `mem_addr`.
- R4: Each granted request, where `mem_req` and `mem_gnt` are both high at a clock edge, advances the fetch pointer by 4.
- R5: A base rewrite during a frame leaves the fetch pointer and the fetched words unchanged. The new value is used from the next frame start.
- R6: Every frame-start pulse sets flag bit 0, even when the base was not rewritten. Writing 1 to a flag bit clears it, but a set in the same cycle takes priority over the clear.
- R7: With control bit 0 = 0, a request is raised only when at least 4 of the 16 FIFO slots are free. With no pops, the FIFO therefore settles at 13 words.
- R8: With control bit 0 = 1, a request is raised only when at least 8 slots are free. With no pops, the FIFO therefore settles at 9 words.
- R9: `mem_req` and `mem_addr` hold steady until the request is granted. At most one read is outstanding, and the FIFO never receives a word while full.
- R10: Popped words come out in fetch order. The k-th word of a frame is the memory word at base + 4k.
- R11: A pop while `pix_valid` is low returns zero on `pix_data`, sets flag bit 1, and leaves the FIFO contents and order unchanged.
- R12: A frame-start pulse empties the FIFO and discards the in-flight word. This includes a read granted in the same cycle as the pulse; that read does not advance the pointer.
- R13: `irq` is high exactly when some flag is set and its enable bit in control is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| frame_start | input | 1 | One-cycle pulse marking a new frame |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Returned word |
| pix_pop | input | 1 | Consumer takes the head word |
| pix_valid | output | 1 | FIFO holds at least one word |
| pix_data | output | 32 | Head word, or zero when empty |
| irq | output | 1 | OR of enabled flags |

## Verification
Two pairs of events can fall in the same cycle: a frame-start pulse with a memory grant, and a frame-start pulse with a software clear of the frame-taken flag. The bench's memory model is armed to grant on exactly the cycle it raises the frame pulse. The bench then checks that the fetch pointer reads back as the bare base, not base + 4, and that the late word never reaches the consumer. The pulse is also driven on the same cycle as a write-1 to flag bit 0, and the flag is expected to read back set.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_TAKEN = 0;
  localparam int FLAG_EMPTY_POP = 1;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_BASE  = 2'd1,
    RA_PTR   = 2'd2,
    RA_FLAGS = 2'd3
  } reg_addr_e;

  // Clear the byte-lane bits so the address names a whole word.
  function automatic logic [ADDR_W-1:0] align_word(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  // Byte address of the following 32-bit word.
  function automatic logic [ADDR_W-1:0] step_word(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(4);
  endfunction

  // Free-slot threshold picked by the control bit.
  function automatic int unsigned refill_mark(input logic hi_sel,
                                              input int unsigned lo,
                                              input int unsigned hi);
    return hi_sel ? hi : lo;
  endfunction

endpackage

// File: rtl/fb_fetch_fifo.sv
module fb_fetch_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic          underflow
);
  // DEPTH is a power of two, so the pointers wrap on their own.
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign empty     = (count == '0);
  assign push_ok   = push && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign underflow = pop && empty;
  assign head      = empty ? '0 : store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + PW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + PW'(1);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fb_fetch_engine.sv
module fb_fetch_engine
  import fb_fetch_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int LOW_MARK  = 4,
  parameter int HIGH_MARK = 8,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] base,
  input  logic              hi_sel,
  input  logic [CW-1:0]     fifo_count,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] curr,
  output logic              push,
  output logic              grant_ev,
  output logic              outstanding
);
  logic          running, stale, launch;
  logic [CW-1:0] free_cnt, mark;

  assign free_cnt = CW'(DEPTH) - fifo_count;
  assign mark     = CW'(refill_mark(hi_sel, LOW_MARK, HIGH_MARK));
  assign grant_ev = mem_req && mem_gnt;
  assign push     = mem_rvalid && outstanding && !stale && !frame_start;
  assign launch   = running && !mem_req && !outstanding && !frame_start
                    && (free_cnt >= mark);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req     <= 1'b0;
      outstanding <= 1'b0;
      stale       <= 1'b0;
      running     <= 1'b0;
      curr        <= '0;
    end else if (frame_start) begin
      running <= 1'b1;
      mem_req <= 1'b0;
      curr    <= base;
      // A read granted now, or still owed, belongs to the old frame.
      if (grant_ev || (outstanding && !mem_rvalid)) begin
        outstanding <= 1'b1;
        stale       <= 1'b1;
      end else begin
        outstanding <= 1'b0;
        stale       <= 1'b0;
      end
    end else begin
      if (grant_ev) begin
        mem_req     <= 1'b0;
        outstanding <= 1'b1;
        curr        <= step_word(curr);
      end else if (launch) begin
        mem_req <= 1'b1;
      end
      if (mem_rvalid && outstanding) begin
        outstanding <= 1'b0;
        stale       <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fb_fetch_regs.sv
module fb_fetch_regs
  import fb_fetch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  reg_addr_e            reg_idx,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic                 taken_ev,
  input  logic                 empty_pop_ev,
  input  logic [ADDR_W-1:0]    curr,
  output logic [ADDR_W-1:0]    base,
  output logic                 hi_sel,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] enables, set_v, clr_v;

  assign set_v = {empty_pop_ev, taken_ev};
  assign clr_v = (reg_wr && reg_idx == RA_FLAGS) ? reg_wdata[NUM_FLAGS-1:0] : '0;
  assign irq   = |(flags & enables);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      hi_sel  <= 1'b0;
      enables <= '0;
      flags   <= '0;
    end else begin
      if (reg_wr && reg_idx == RA_BASE) base <= align_word(reg_wdata);
      if (reg_wr && reg_idx == RA_CTRL) begin
        hi_sel  <= reg_wdata[0];
        enables <= reg_wdata[NUM_FLAGS:1];
      end
      // A new event wins over a simultaneous clear.
      flags <= (flags & ~clr_v) | set_v;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_idx)
      RA_CTRL:  reg_rdata = {{(DATA_W-NUM_FLAGS-1){1'b0}}, enables, hi_sel};
      RA_BASE:  reg_rdata = base;
      RA_PTR:   reg_rdata = curr;
      RA_FLAGS: reg_rdata = {{(DATA_W-NUM_FLAGS){1'b0}}, flags};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fb_fetch_ctrl.sv
module fb_fetch_ctrl
  import fb_fetch_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int LOW_MARK  = 4,
  parameter int HIGH_MARK = 8,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              frame_start,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              pix_pop,
  output logic              pix_valid,
  output logic [DATA_W-1:0] pix_data,
  output logic              irq
);
  // Named internal events, also observed by the bound checker.
  logic [ADDR_W-1:0]    base_addr, curr_addr;
  logic [CW-1:0]        fifo_count;
  logic [NUM_FLAGS-1:0] flags;
  logic                 hi_sel, push_ev, grant_ev, outstanding;
  logic                 empty_pop_ev, fifo_empty;

  assign mem_addr  = curr_addr;
  assign pix_valid = !fifo_empty;

  fb_fetch_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_idx      (reg_addr_e'(reg_addr)),
    .reg_wdata    (reg_wdata),
    .taken_ev     (frame_start),
    .empty_pop_ev (empty_pop_ev),
    .curr         (curr_addr),
    .base         (base_addr),
    .hi_sel       (hi_sel),
    .flags        (flags),
    .reg_rdata    (reg_rdata),
    .irq          (irq)
  );

  fb_fetch_engine #(
    .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .base        (base_addr),
    .hi_sel      (hi_sel),
    .fifo_count  (fifo_count),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .mem_req     (mem_req),
    .curr        (curr_addr),
    .push        (push_ev),
    .grant_ev    (grant_ev),
    .outstanding (outstanding)
  );

  fb_fetch_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (frame_start),
    .push      (push_ev),
    .push_data (mem_rdata),
    .pop       (pix_pop),
    .head      (pix_data),
    .empty     (fifo_empty),
    .count     (fifo_count),
    .underflow (empty_pop_ev)
  );
endmodule

// File: rtl/fb_fetch_ctrl_chk.sv
module fb_fetch_ctrl_chk #(
  parameter int DEPTH     = 16,
  parameter int LOW_MARK  = 4,
  parameter int HIGH_MARK = 8,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [31:0]   mem_addr,
  input logic          pix_pop,
  input logic          pix_valid,
  input logic [31:0]   curr,
  input logic [31:0]   base,
  input logic          push_ev,
  input logic          outstanding,
  input logic          hi_sel,
  input logic [CW-1:0] count,
  input logic [1:0]    flags
);
  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !frame_start |=> mem_req && $stable(mem_addr));

  p_single_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outstanding);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |-> int'(count) < DEPTH);

  p_base_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> curr == $past(base));

  p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && !frame_start |=> curr == $past(curr) + 32'd4);

  p_taken_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> flags[0]);

  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pix_pop && !pix_valid |=> flags[1]);

  p_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !pix_valid);

  // R7 and R8: a new request needs the selected amount of free room.
  p_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |->
      int'($past(count)) + ($past(hi_sel) ? HIGH_MARK : LOW_MARK) <= DEPTH);
endmodule

bind fb_fetch_ctrl fb_fetch_ctrl_chk #(
  .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .mem_req     (mem_req),
  .mem_gnt     (mem_gnt),
  .mem_addr    (mem_addr),
  .pix_pop     (pix_pop),
  .pix_valid   (pix_valid),
  .curr        (curr_addr),
  .base        (base_addr),
  .push_ev     (push_ev),
  .outstanding (outstanding),
  .hi_sel      (hi_sel),
  .count       (fifo_count),
  .flags       (flags)
);

// File: tb/fb_fetch_ctrl_tb_top.sv
module fb_fetch_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fs_tb = 1'b0, fs_mem = 1'b0;
  logic        frame_start;
  logic        mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        pix_pop = 1'b0, pix_valid, irq;
  logic [31:0] pix_data;

  int n_chk = 0, n_fail = 0, popped = 0, cyc = 0;
  logic [31:0] exp_q[$];

  // memory model controls
  logic gnt_en = 1'b0, fs_arm = 1'b0, fs_fired = 1'b0;
  int   lat = 1, lat_cnt = 0;
  logic [31:0] lat_addr = '0;

  assign frame_start = fs_tb | fs_mem;

  always #5 clk = ~clk;

  fb_fetch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_pop(pix_pop),
    .pix_valid(pix_valid), .pix_data(pix_data), .irq(irq)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hC3C3_0000;
  endfunction

  task automatic chk(input bit ok, input string rq,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: grants at negedge, returns data lat cycles later
  always @(negedge clk) begin
    mem_gnt = 1'b0;
    mem_rvalid = 1'b0;
    fs_mem = 1'b0;
    if (!fs_arm) fs_fired = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = pat(lat_addr);
      end
    end else if (rst_n && mem_req && (gnt_en || (fs_arm && !fs_fired))) begin
      mem_gnt = 1'b1;
      lat_addr = mem_addr;
      lat_cnt = lat;
      if (fs_arm) begin
        fs_mem = 1'b1;
        fs_fired = 1'b1;
      end
    end
  end

  // scoreboard monitor: compares each accepted pop against the queue
  always @(negedge clk) begin
    #1;
    if (rst_n && pix_pop && pix_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected word", pix_data, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(pix_data == e, "R10 fetch order", pix_data, e);
        popped++;
      end
    end
  end

  // driver: load the expected words of a frame based at b
  task automatic load_exp(input logic [31:0] b);
    exp_q.delete();
    for (int k = 0; k < 64; k++) exp_q.push_back(pat(b + 32'(4 * k)));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic frame(input logic [31:0] b);
    @(negedge clk);
    fs_tb = 1'b1;
    load_exp(b);
    @(negedge clk);
    fs_tb = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    pix_pop = 1'b1;
    @(negedge clk);
    pix_pop = 1'b0;
  endtask

  task automatic drain(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (pix_valid) begin
        pix_pop = 1'b1;
        n++;
      end else begin
        pix_pop = 1'b0;
        break;
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, held;
    int n, p0;

    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state, nothing fetched before a frame
    #1;
    chk(!mem_req, "R1 no request", 32'(mem_req), 32'h0);
    chk(!pix_valid, "R1 empty", 32'(pix_valid), 32'h0);
    chk(!irq, "R1 irq", 32'(irq), 32'h0);
    rd(2'd2, d); chk(d == 32'h0, "R1 pointer", d, 32'h0);
    rd(2'd3, d); chk(d == 32'h0, "R1 flags", d, 32'h0);

    // R2 base alignment
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0000_1003);
    rd(2'd1, d); chk(d == 32'h0000_1000, "R2 base aligned", d, 32'h0000_1000);

    // R3 frame start loads pointer
    frame(32'h0000_1000);
    idle(3);
    rd(2'd2, d); chk(d == 32'h0000_1000, "R3 pointer load", d, 32'h0000_1000);
    #1 chk(mem_req && mem_addr == 32'h0000_1000, "R3 first address", mem_addr, 32'h0000_1000);
    rd(2'd3, d); chk(d[0], "R6 taken flag", d, 32'h1);
    #1 chk(!irq, "R13 irq masked", 32'(irq), 32'h0);
    wr(2'd0, 32'h2);
    #1 chk(irq, "R13 irq enabled", 32'(irq), 32'h1);
    wr(2'd3, 32'h1);
    rd(2'd3, d); chk(d == 32'h0, "R6 write-1 clear", d, 32'h0);
    #1 chk(!irq, "R13 irq after clear", 32'(irq), 32'h0);

    // R7 low mark: settles at 13 words
    gnt_en = 1'b1;
    idle(80);
    #1 chk(!mem_req, "R7 no request at 3 free", 32'(mem_req), 32'h0);
    rd(2'd2, d); chk(d == 32'h0000_1034, "R4 pointer after 13", d, 32'h0000_1034);
    gnt_en = 1'b0;
    // R5 rewrite mid-frame has no effect yet
    wr(2'd1, 32'h0000_2000);
    rd(2'd2, d); chk(d == 32'h0000_1034, "R5 pointer unchanged", d, 32'h0000_1034);
    pop_one();
    idle(3);
    #1 chk(mem_req, "R7 request at 4 free", 32'(mem_req), 32'h1);
    drain(n);
    chk(n == 12, "R7 fill level", 32'(n + 1), 32'd13);

    // R8 high mark: settles at 9 words
    wr(2'd0, 32'h3);
    frame(32'h0000_2000);
    rd(2'd2, d); chk(d == 32'h0000_2000, "R5 new base used", d, 32'h0000_2000);
    gnt_en = 1'b1;
    idle(80);
    #1 chk(!mem_req, "R8 no request at 7 free", 32'(mem_req), 32'h0);
    gnt_en = 1'b0;
    pop_one();
    idle(3);
    #1 chk(mem_req, "R8 request at 8 free", 32'(mem_req), 32'h1);
    drain(n);
    chk(n == 8, "R8 fill level", 32'(n + 1), 32'd9);

    // R11 pop while empty
    wr(2'd0, 32'h4);
    wr(2'd3, 32'h3);
    @(negedge clk);
    pix_pop = 1'b1;
    #1 chk(pix_data == 32'h0, "R11 zero data", pix_data, 32'h0);
    @(negedge clk);
    pix_pop = 1'b0;
    rd(2'd3, d); chk(d == 32'h2, "R11 flag", d, 32'h2);
    #1 chk(irq, "R13 empty-pop irq", 32'(irq), 32'h1);
    p0 = popped;
    gnt_en = 1'b1;
    idle(20);
    pop_one(); pop_one();
    chk(popped == p0 + 2, "R11 order kept", 32'(popped - p0), 32'd2);

    // R12 flush with a read in flight
    gnt_en = 1'b0;
    idle(5);
    drain(n);
    gnt_en = 1'b1;
    idle(40);
    lat = 6;
    pop_one();
    do @(posedge clk); while (lat_cnt == 0);
    wr(2'd3, 32'h3);
    frame(32'h0000_2000);
    #1 chk(!pix_valid, "R12 flushed", 32'(pix_valid), 32'h0);
    rd(2'd3, d); chk(d[0], "R6 taken without rewrite", d, 32'h1);
    lat = 1;
    idle(40);
    p0 = popped;
    pop_one(); pop_one(); pop_one();
    chk(popped == p0 + 3, "R12 new frame words", 32'(popped - p0), 32'd3);

    // R12 grant in the same cycle as the frame pulse
    gnt_en = 1'b0;
    idle(5);
    drain(n);
    idle(3);
    wr(2'd1, 32'h0000_3000);
    load_exp(32'h0000_3000);
    fs_arm = 1'b1;
    do @(posedge clk); while (!fs_fired);
    fs_arm = 1'b0;
    idle(10);
    rd(2'd2, d); chk(d == 32'h0000_3000, "R12 pointer not stepped", d, 32'h0000_3000);
    #1 chk(!pix_valid, "R12 late word dropped", 32'(pix_valid), 32'h0);

    // R9 request held while not granted
    idle(3);
    held = mem_addr;
    idle(10);
    #1 chk(mem_req && mem_addr == held, "R9 request held", mem_addr, held);
    gnt_en = 1'b1;
    idle(30);
    p0 = popped;
    pop_one(); pop_one();
    chk(popped == p0 + 2, "R10 words after pulse", 32'(popped - p0), 32'd2);

    // R6 set beats clear in the same cycle
    @(negedge clk);
    fs_tb = 1'b1; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h1;
    load_exp(32'h0000_3000);
    @(negedge clk);
    fs_tb = 1'b0; reg_wr = 1'b0;
    rd(2'd3, d); chk(d[0], "R6 set wins", d, 32'h1);

    idle(5);
    finish_run();
  end
endmodule